// File: doc/BRIEF.md
# Shared Interrupt Source Controller

A register-programmed controller for a parameterised group of shared interrupt sources. Each source has its own sense setting (polarity, level or edge, dual-edge), an enable bit, a pending bit, an output-pin assignment and a one-hot processor assignment. The outputs are a flat vector with one line for each processor and pin pair. A line is high whenever at least one enabled pending source is routed to it.

Software sets up the controller over a simple single-cycle write/read bus. Enable bits are changed by writing a source index to a set-enable or clear-enable register, so no read-modify-write is needed. Edge-pending state is raised or cleared through one index-based edge-control register. Raising it is the software-triggered path for inter-processor signalling. Clearing it is the acknowledge for edge sources. A raw pending bitmap and a read-only configuration word can be read back.

Register map (word addresses): 0x000 configuration; 0x001 set-enable; 0x002 clear-enable; 0x003 edge control; 0x040+w pending word w; 0x100+i sense of source i; 0x200+i pin map of source i; 0x300+i processor map of source i. A read returns its data on `rdata_o` one cycle after `rd_en_i`.

Top module: `irq_share_ctrl`

## Requirements
- R1: After reset, every source is active-high, level-sensed and disabled. Its sense register reads 0x1, its pin and processor maps read 0, and all `irq_o` lines are low.
- R2: The configuration word at 0x000 holds (NUM_SRC/8 - 1) in bits [7:0], NUM_TGT in bits [15:8] and NUM_PIN in bits [23:16], so the source count is (field + 1) x 8.
- R3: A write to 0x001 with a source index in wdata[7:0] enables only that source.
- R4: A write to 0x002 with a source index in wdata[7:0] disables only that source.
- R5: A write to 0x003 with wdata[31]=1 and an index in wdata[7:0] makes that edge-sensed source pending in the next cycle.
- R6: A write to 0x003 with wdata[31]=0 and an index clears that source's latched edge-pending state. For a level-sensed source, edge-control writes of either kind have no effect on pending.
- R7: Sense bit 1 (trigger) = 0 selects level sensing. In that mode sense bit 0 (polarity) = 1 means active-high and 0 means active-low. The source is pending exactly while its synchronised input is at the active level.
- R8: With trigger = 1 and dual (sense bit 2) = 0, polarity 1 latches pending on a rising edge and polarity 0 latches it on a falling edge. The latch holds until an edge-control clear.
- R9: With trigger = 1 and dual = 1, both edges latch pending and polarity is ignored.
- R10: Pending word w at 0x040+w holds in bit b the raw pending state of source 32w+b, whatever its enable bit is. Bits above NUM_SRC read 0.
- R11: Line irq_o[t*NUM_PIN+p] is high when some source is pending, enabled, has pin-map bit 31 set with pin field (bits [PIN_W-1:0]) equal to p, and has processor-map bit t set.
- R12: Each source input passes through two flip-flops before sensing. A level change on `src_i` first affects pending after the second rising clock edge.
- R13: The sense (bits [2:0]), pin map and processor map of each source read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Asynchronous shared interrupt inputs |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 10 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after rd_en_i |
| irq_o | output | NUM_TGT*NUM_PIN | Interrupt line per processor and pin, index t*NUM_PIN+p |

## Verification
The routing function is exercised in several ways. Two sources share one route while their enable bits are toggled one at a time, which shows that set-enable and clear-enable touch only the indexed source. A single source fans out to two processors and then loses its map-enable flag, which separates the processor decode from the pin decode. The sensing logic is tried with each trigger mode: active-low level, rising, falling and dual-edge. Each is driven with both input transitions, so that a polarity or edge-select error shows up as a pending bit that is present or missing. Software raise and clear are applied to an edge source and to a level source, which shows that the latch only exists in edge mode. A source in the second pending word and a check one edge into synchronisation cover the bitmap packing and the input latency.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 8;

  localparam logic [ADDR_W-1:0] REG_CFG  = 10'h000;
  localparam logic [ADDR_W-1:0] REG_MSET = 10'h001;
  localparam logic [ADDR_W-1:0] REG_MCLR = 10'h002;
  localparam logic [ADDR_W-1:0] REG_EDGE = 10'h003;

  // addr_i[9:8] bank select
  localparam logic [1:0] BANK_CTL  = 2'd0;
  localparam logic [1:0] BANK_SNS  = 2'd1;
  localparam logic [1:0] BANK_PIN  = 2'd2;
  localparam logic [1:0] BANK_TGT  = 2'd3;
  localparam logic [1:0] CTL_PEND  = 2'b01;  // addr_i[7:6] in control bank

  localparam int SNS_POL  = 0;
  localparam int SNS_TRIG = 1;
  localparam int SNS_DUAL = 2;
  localparam logic [2:0] SNS_RST = 3'b001;

  localparam int EDGE_SET_BIT = 31;
  localparam int PIN_EN_BIT   = 31;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_src_slice.sv
module irq_src_slice
  import irq_pkg::*;
#(
  parameter int PIN_W   = 3,
  parameter int NUM_TGT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lvl_i,
  input  logic               mask_set_i,
  input  logic               mask_clr_i,
  input  logic               wedge_set_i,
  input  logic               wedge_clr_i,
  input  logic               sense_we_i,
  input  logic               pin_we_i,
  input  logic               tgt_we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               pend_o,
  output logic               mask_o,
  output logic [2:0]         sense_o,
  output logic               pin_en_o,
  output logic [PIN_W-1:0]   pin_o,
  output logic [NUM_TGT-1:0] tgt_o
);
  logic [2:0]         sense_q;
  logic               mask_q, prev_q, edge_q, edge_ev;
  logic               pin_en_q;
  logic [PIN_W-1:0]   pin_q;
  logic [NUM_TGT-1:0] tgt_q;
  logic               pol, trig, dual;

  assign pol  = sense_q[SNS_POL];
  assign trig = sense_q[SNS_TRIG];
  assign dual = sense_q[SNS_DUAL];

  always_comb begin
    if (dual)     edge_ev = lvl_i ^ prev_q;
    else if (pol) edge_ev = lvl_i & ~prev_q;
    else          edge_ev = ~lvl_i & prev_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q  <= SNS_RST;
      mask_q   <= 1'b0;
      prev_q   <= 1'b0;
      edge_q   <= 1'b0;
      pin_en_q <= 1'b0;
      pin_q    <= '0;
      tgt_q    <= '0;
    end else begin
      prev_q <= lvl_i;
      if (mask_set_i)      mask_q <= 1'b1;
      else if (mask_clr_i) mask_q <= 1'b0;
      // latch exists only in edge mode; a new edge beats a clear
      if (!trig)                       edge_q <= 1'b0;
      else if (edge_ev || wedge_set_i) edge_q <= 1'b1;
      else if (wedge_clr_i)            edge_q <= 1'b0;
      if (sense_we_i) sense_q <= wdata_i[2:0];
      if (pin_we_i) begin
        pin_en_q <= wdata_i[PIN_EN_BIT];
        pin_q    <= wdata_i[PIN_W-1:0];
      end
      if (tgt_we_i) tgt_q <= wdata_i[NUM_TGT-1:0];
    end
  end

  assign pend_o   = trig ? edge_q : (lvl_i == pol);
  assign mask_o   = mask_q;
  assign sense_o  = sense_q;
  assign pin_en_o = pin_en_q;
  assign pin_o    = pin_q;
  assign tgt_o    = tgt_q;

  // R3
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_set_i |=> mask_o);
  // R4
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_clr_i && !mask_set_i) |=> !mask_o);
  // R5
  wedge_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wedge_set_i && trig && !sense_we_i) |=> pend_o);
  // R6
  wedge_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wedge_clr_i && trig && !edge_ev && !sense_we_i) |=> !pend_o);
  // R8
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && trig && !wedge_clr_i && !sense_we_i) |=> pend_o);
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int NUM_SRC = 40,
  parameter int NUM_TGT = 4,
  parameter int NUM_PIN = 6,
  parameter int PIN_W   = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_SRC-1:0]                act_i,
  input  logic [NUM_SRC-1:0]                pin_en_i,
  input  logic [NUM_SRC-1:0][PIN_W-1:0]     pin_i,
  input  logic [NUM_SRC-1:0][NUM_TGT-1:0]   tgt_i,
  output logic [NUM_TGT*NUM_PIN-1:0]        irq_o
);
  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
      logic hit;
      always_comb begin
        hit = 1'b0;
        for (int s = 0; s < NUM_SRC; s++)
          hit = hit | (act_i[s] & pin_en_i[s] & (pin_i[s] == PIN_W'(p)) & tgt_i[s][t]);
      end
      assign irq_o[t*NUM_PIN+p] = hit;
    end
  end

  // R11
  no_src_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == '0) |-> (irq_o == '0));
  // R11
  unrouted_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((act_i & pin_en_i) == '0) |-> (irq_o == '0));
endmodule

// File: rtl/irq_share_ctrl.sv
module irq_share_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_TGT = 4,
  parameter int NUM_PIN = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_SRC-1:0]         src_i,
  input  logic                       wr_en_i,
  input  logic                       rd_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_TGT*NUM_PIN-1:0] irq_o
);
  localparam int PIN_W   = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1;
  localparam int NW      = (NUM_SRC + 31) / 32;
  localparam int CNT_FLD = NUM_SRC / 8 - 1;

  logic [NUM_SRC-1:0]              lvl, pend, mask, pin_en, act;
  logic [NUM_SRC-1:0][2:0]         sense;
  logic [NUM_SRC-1:0][PIN_W-1:0]   pin;
  logic [NUM_SRC-1:0][NUM_TGT-1:0] tgt;
  logic [NW-1:0][31:0]             pend_words;
  logic [DATA_W-1:0]               cfg_word, rd_val, rdata_q;
  logic                            wr_mset, wr_mclr, wr_edge;
  logic [IDX_W-1:0]                widx;

  irq_sync #(.W(NUM_SRC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (lvl)
  );

  assign wr_mset = wr_en_i && (addr_i == REG_MSET);
  assign wr_mclr = wr_en_i && (addr_i == REG_MCLR);
  assign wr_edge = wr_en_i && (addr_i == REG_EDGE);
  assign widx    = wdata_i[IDX_W-1:0];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic idx_hit, reg_hit;
    assign idx_hit = (widx == IDX_W'(i));
    assign reg_hit = wr_en_i && (addr_i[7:0] == 8'(i));

    irq_src_slice #(.PIN_W(PIN_W), .NUM_TGT(NUM_TGT)) u_slice (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lvl_i      (lvl[i]),
      .mask_set_i (wr_mset && idx_hit),
      .mask_clr_i (wr_mclr && idx_hit),
      .wedge_set_i(wr_edge && idx_hit && wdata_i[EDGE_SET_BIT]),
      .wedge_clr_i(wr_edge && idx_hit && !wdata_i[EDGE_SET_BIT]),
      .sense_we_i (reg_hit && (addr_i[9:8] == BANK_SNS)),
      .pin_we_i   (reg_hit && (addr_i[9:8] == BANK_PIN)),
      .tgt_we_i   (reg_hit && (addr_i[9:8] == BANK_TGT)),
      .wdata_i    (wdata_i),
      .pend_o     (pend[i]),
      .mask_o     (mask[i]),
      .sense_o    (sense[i]),
      .pin_en_o   (pin_en[i]),
      .pin_o      (pin[i]),
      .tgt_o      (tgt[i])
    );
  end

  assign act = pend & mask;

  irq_route #(
    .NUM_SRC(NUM_SRC), .NUM_TGT(NUM_TGT), .NUM_PIN(NUM_PIN), .PIN_W(PIN_W)
  ) u_route (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (act),
    .pin_en_i(pin_en),
    .pin_i   (pin),
    .tgt_i   (tgt),
    .irq_o   (irq_o)
  );

  always_comb begin
    pend_words = '0;
    for (int i = 0; i < NUM_SRC; i++) pend_words[i/32][i%32] = pend[i];
  end

  always_comb begin
    cfg_word        = '0;
    cfg_word[7:0]   = 8'(CNT_FLD);
    cfg_word[15:8]  = 8'(NUM_TGT);
    cfg_word[23:16] = 8'(NUM_PIN);
  end

  always_comb begin
    rd_val = '0;
    unique case (addr_i[9:8])
      BANK_CTL: begin
        if (addr_i == REG_CFG) rd_val = cfg_word;
        else if (addr_i[7:6] == CTL_PEND)
          for (int w = 0; w < NW; w++)
            if (addr_i[5:0] == 6'(w)) rd_val = pend_words[w];
      end
      BANK_SNS:
        for (int i = 0; i < NUM_SRC; i++)
          if (addr_i[7:0] == 8'(i)) rd_val[2:0] = sense[i];
      BANK_PIN:
        for (int i = 0; i < NUM_SRC; i++)
          if (addr_i[7:0] == 8'(i)) begin
            rd_val[PIN_EN_BIT]  = pin_en[i];
            rd_val[PIN_W-1:0]   = pin[i];
          end
      default:
        for (int i = 0; i < NUM_SRC; i++)
          if (addr_i[7:0] == 8'(i)) rd_val[NUM_TGT-1:0] = tgt[i];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  // R2
  cfg_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == REG_CFG) |=> ((int'(rdata_o[7:0]) + 1) * 8 == NUM_SRC));
  // R4
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> (irq_o == '0));
endmodule

// File: tb/tb_irq_share_ctrl.sv
`timescale 1ns/1ps
module tb_irq_share_ctrl;
  localparam int NUM_SRC = 40;
  localparam int NUM_TGT = 4;
  localparam int NUM_PIN = 6;
  localparam int NI = NUM_TGT*NUM_PIN;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NUM_SRC-1:0] src_i = '0;
  logic              wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [9:0]        addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic [NI-1:0]     irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_share_ctrl #(.NUM_SRC(NUM_SRC), .NUM_TGT(NUM_TGT), .NUM_PIN(NUM_PIN)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always @(posedge clk_i) rd_d <= rd_en_i;

  // monitor: pops expected read data when the registered response appears
  always @(negedge clk_i) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata_o !== e) begin
        n_bad++;
        $display("FAIL %s: rdata actual=%h expected=%h", t, rdata_o, e);
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string t);
    @(negedge clk_i);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
  endtask

  task automatic chk_irq(input logic [NI-1:0] e, input string t);
    n_chk++;
    if (irq_o !== e) begin
      n_bad++;
      $display("FAIL %s: irq actual=%h expected=%h", t, irq_o, e);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  localparam logic [NI-1:0] B8  = NI'(1) << 8;   // target 1, pin 2
  localparam logic [NI-1:0] B23 = NI'(1) << 23;  // target 3, pin 5
  localparam logic [NI-1:0] B5  = NI'(1) << 5;   // target 0, pin 5

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    chk_irq('0, "R1 reset lines");
    rd(10'h100, 32'h1, "R1 reset sense");
    rd(10'h203, 32'h0, "R1 reset pin map");
    rd(10'h040, 32'h0, "R1 reset pending");
    rd(10'h000, 32'h0006_0404, "R2 config word");

    // sources 3 and 4 both routed to target 1 pin 2
    wr(10'h203, 32'h8000_0002); wr(10'h303, 32'h2);
    wr(10'h204, 32'h8000_0002); wr(10'h304, 32'h2);
    rd(10'h203, 32'h8000_0002, "R13 pin map readback");
    rd(10'h304, 32'h2, "R13 target map readback");
    wr(10'h001, 32'd3);
    @(negedge clk_i);
    src_i[3] = 1'b1;
    @(negedge clk_i);
    chk_irq('0, "R12 one edge into sync");
    @(negedge clk_i);
    chk_irq(B8, "R12 R11 two edges into sync");
    src_i[4] = 1'b1;
    wr(10'h002, 32'd3);
    settle();
    chk_irq('0, "R4 disable indexed source");
    rd(10'h040, 32'h18, "R10 raw pending ignores enable");
    wr(10'h001, 32'd3);
    chk_irq(B8, "R3 enable indexed source only");
    wr(10'h001, 32'd4); wr(10'h002, 32'd3);
    chk_irq(B8, "R4 clear leaves other source");
    wr(10'h002, 32'd4);
    chk_irq('0, "R4 clear last source");

    // active-low level on source 4
    wr(10'h104, 32'h0);
    rd(10'h104, 32'h0, "R13 sense readback");
    rd(10'h040, 32'h08, "R7 active-low input high");
    src_i[4] = 1'b0;
    settle();
    rd(10'h040, 32'h18, "R7 active-low input low");

    // rising edge on source 6, target 3 pin 5
    wr(10'h206, 32'h8000_0005); wr(10'h306, 32'h8);
    wr(10'h106, 32'h3); wr(10'h001, 32'd6);
    src_i[6] = 1'b1; settle(); src_i[6] = 1'b0; settle();
    chk_irq(B23, "R8 rising latched and held");
    wr(10'h003, 32'd6);
    chk_irq('0, "R6 edge clear");
    // falling edge
    wr(10'h106, 32'h2);
    src_i[6] = 1'b1; settle();
    chk_irq('0, "R8 falling ignores rise");
    src_i[6] = 1'b0; settle();
    chk_irq(B23, "R8 falling latched");
    wr(10'h003, 32'd6);
    // dual edge, polarity bit 0 ignored
    wr(10'h106, 32'h6);
    src_i[6] = 1'b1; settle();
    chk_irq(B23, "R9 dual rise");
    wr(10'h003, 32'd6);
    chk_irq('0, "R9 dual cleared");
    src_i[6] = 1'b0; settle();
    chk_irq(B23, "R9 dual fall");
    wr(10'h003, 32'd6);

    // software raise
    wr(10'h003, 32'h8000_0006);
    chk_irq(B23, "R5 software raise");
    rd(10'h040, 32'h58, "R5 pending bit after raise");
    wr(10'h003, 32'd6);
    rd(10'h040, 32'h18, "R6 pending cleared");
    wr(10'h003, 32'h8000_0007);
    rd(10'h040, 32'h18, "R6 level source ignores raise");
    wr(10'h003, 32'd3);
    rd(10'h040, 32'h18, "R6 level source ignores clear");

    // second pending word
    src_i[36] = 1'b1; settle();
    rd(10'h041, 32'h10, "R10 second word");

    // fan-out to targets 0 and 3, then drop map enable
    wr(10'h306, 32'h9);
    wr(10'h003, 32'h8000_0006);
    chk_irq(B23 | B5, "R11 multi-target");
    wr(10'h206, 32'h0000_0005);
    chk_irq('0, "R11 map enable off");

    repeat (4) @(negedge clk_i);
    summary();
  end
endmodule